// File: doc/BRIEF.md
# Card Reader Channel Device Controller

This block is the control sequencer that sits between an I/O channel and a punched-card reader. The host issues one of five commands: start, test, test device, halt and acknowledge-interrupt. Each command returns an 8-bit status word in the same cycle. A start on an idle, loaded reader requests an order code from the channel and checks it. The order picks the translation mode (automatic or binary) and the output stacker. The controller then paces the column transfers with a separate formatter, one request per byte. The reader has no data path of its own. Every request to the channel and to the formatter is separated from the one before by a fixed control delay.

A card ends when the channel byte count runs out or when the card's data is exhausted. If exactly one of those two conditions holds, the controller flags an incorrect length. At card end it raises channel end, adds one to the selected stacker counter and takes one card out of the hopper. If the channel reports command chaining, it fetches a new order for the next card. Otherwise it returns to idle. A loaded hopper marks the reader as attached, and the last card read detaches it.

Top module: `crd_chan_ctl`

## Requirements
- R1: An order code is accepted only when bits 7:6 are 00, bits 1:0 are 10 and bits 5:4 are not 10. Any other code raises unusual_end in the cycle it is presented, sets int_pend and returns the block to idle.
- R2: After a valid order, mode_auto equals order bit 2 (1 = automatic, 0 = binary).
- R3: Order bits 5:4 = 01 select stk_sel 1 (alternate 1) and 11 select stk_sel 2 (alternate 2). All other values select stk_sel 0 (normal). Card end increments only the selected counter.
- R4: A start (cmd_op 0) launches the sequence only when attached is 1 and the block is idle. It returns the test status of the cycle before launch. The first ord_req follows exactly CTL_DLY cycles after the launching edge.
- R5: A halt (cmd_op 3) clears int_pend. When the block is busy, the halt also aborts the sequence to idle and raises unusual_end in that cycle. When the block is idle, the halt raises no unusual_end.
- R6: On the transfer acknowledge that ends a card (xfer_zbc or xfer_last high), len_err is high exactly when xfer_zbc differs from xfer_last. While both are low, transfers continue.
- R7: At card end, chan_end is high for one cycle and hopper_cnt decrements by one. When hopper_cnt reaches zero, attached drops to 0.
- R8: If chain_in is high during chan_end, the next ord_req comes CTL_DLY cycles later. Otherwise the block goes idle with int_pend set.
- R9: Test status (cmd_op 1) is {attached, busy, busy, 5'b0}: bit 7 is the automatic/attached bit, bit 6 is controller busy and bit 5 is device busy.
- R10: Test-device status (cmd_op 2) is the unit status, with the data-error flag in bit 3, when the reader is attached and the hopper is non-empty. Otherwise it is 8'h04 (not ready). data_err_in sets the flag during a sequence, and the next launch clears it.
- R11: Each stacker counter is STK_W bits wide and wraps to zero on overflow.
- R12: Every transfer request follows the previous acknowledge by exactly CTL_DLY cycles. chan_end follows the last acknowledge by CTL_DLY cycles. ord_req and xfer_req are never high together.
- R13: Acknowledge-interrupt (cmd_op 4) returns status 0 and clears int_pend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Host command strobe |
| cmd_op | input | 3 | 0 start, 1 test, 2 test device, 3 halt, 4 acknowledge |
| status_word | output | 8 | Status returned to the host command in the same cycle |
| hopper_load | input | 1 | Load the hopper count |
| hopper_init | input | HOP_W | Card count to load |
| ord_req | output | 1 | Request for an order code from the channel |
| ord_valid | input | 1 | Order code presented |
| ord_code | input | 8 | Order code |
| xfer_req | output | 1 | Request for one column byte transfer |
| xfer_ack | input | 1 | Byte transferred |
| xfer_zbc | input | 1 | Channel byte count reached zero with this byte |
| xfer_last | input | 1 | This byte exhausts the card data |
| data_err_in | input | 1 | Invalid punch detected by the formatter |
| chain_in | input | 1 | Channel reports command chaining at card end |
| mode_auto | output | 1 | 1 automatic, 0 binary |
| stk_sel | output | 2 | Selected stacker: 0 normal, 1 alternate 1, 2 alternate 2 |
| chan_end | output | 1 | Channel end pulse at card end |
| unusual_end | output | 1 | Unusual end pulse |
| len_err | output | 1 | Incorrect length pulse |
| int_pend | output | 1 | Interrupt pending |
| attached | output | 1 | Reader loaded with cards |
| hopper_cnt | output | HOP_W | Cards left in the hopper |
| stk_norm | output | STK_W | Normal stacker count |
| stk_alt1 | output | STK_W | Alternate stacker 1 count |
| stk_alt2 | output | STK_W | Alternate stacker 2 count |

## Verification
The assertions watch on every cycle that the two request strobes never overlap and that channel end never coincides with unusual end. They also check that a halt on a busy block and an unchained card end both leave it idle, and that a start on a detached reader does nothing. Further cycle-by-cycle checks cover the hopper stepping down at each card end, acknowledge clearing the interrupt, and incorrect length appearing only on a final acknowledge with mismatched end conditions. Only the bench scenarios can show the rest. These are the full order-code sweep with its mode and stacker choices, the exact control delays, the counter wrap, the chained second card, the data-error status lifecycle and detachment on the last card.

// File: rtl/crd_pkg.sv
package crd_pkg;

  typedef enum logic [2:0] {
    HC_START = 3'd0,
    HC_TEST  = 3'd1,
    HC_TDEV  = 3'd2,
    HC_HALT  = 3'd3,
    HC_ACK   = 3'd4
  } host_op_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_FETCH,
    SQ_XFER,
    SQ_END
  } seq_st_e;

  localparam int NSTK = 3;
  localparam logic [1:0] STK_NORM = 2'd0;
  localparam logic [1:0] STK_ALT1 = 2'd1;
  localparam logic [1:0] STK_ALT2 = 2'd2;

  localparam int ST_AUTO_B  = 7;
  localparam int ST_CBUSY_B = 6;
  localparam int ST_DBUSY_B = 5;
  localparam int ST_NRDY_B  = 2;
  localparam int UST_DERR_B = 3;

  // accepted order codes: low pair 10, top pair 00, field 5:4 not 10
  function automatic logic ord_ok(input logic [7:0] code);
    return (code[7:6] == 2'b00) && (code[1:0] == 2'b10) && (code[5:4] != 2'b10);
  endfunction

  function automatic logic [1:0] ord_stack(input logic [7:0] code);
    logic [1:0] s;
    case (code[5:4])
      2'b01:   s = STK_ALT1;
      2'b11:   s = STK_ALT2;
      default: s = STK_NORM;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/crd_dly_timer.sv
module crd_dly_timer #(
  parameter int CTL_DLY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic done
);
  localparam int CW = (CTL_DLY < 1) ? 1 : $clog2(CTL_DLY + 1);
  localparam logic [CW-1:0] RELOAD = CW'(CTL_DLY);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? RELOAD : (cnt_q - ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/crd_seq.sv
module crd_seq
  import crd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_go,
  input  logic       halt_go,
  input  logic       tmr_done,
  input  logic       ord_valid,
  input  logic [7:0] ord_code,
  input  logic       xfer_ack,
  input  logic       xfer_zbc,
  input  logic       xfer_last,
  input  logic       chain_in,
  output logic       tmr_load,
  output logic       busy,
  output logic       ord_req,
  output logic       xfer_req,
  output logic       card_done,
  output logic       bad_order,
  output logic       len_err,
  output logic       mode_auto,
  output logic [1:0] stk_sel
);
  seq_st_e    st_q, st_d;
  logic       mode_q, mode_d;
  logic [1:0] stk_q, stk_d;
  logic       st_en;

  always_comb begin
    st_d      = st_q;
    mode_d    = mode_q;
    stk_d     = stk_q;
    tmr_load  = 1'b0;
    ord_req   = 1'b0;
    xfer_req  = 1'b0;
    card_done = 1'b0;
    bad_order = 1'b0;
    len_err   = 1'b0;
    if (halt_go) begin
      st_d = SQ_IDLE;
    end else begin
      case (st_q)
        SQ_IDLE: begin
          if (start_go) begin
            st_d     = SQ_FETCH;
            tmr_load = 1'b1;
            stk_d    = STK_NORM;
          end
        end
        SQ_FETCH: begin
          if (tmr_done) begin
            ord_req = 1'b1;
            if (ord_valid) begin
              if (ord_ok(ord_code)) begin
                st_d     = SQ_XFER;
                tmr_load = 1'b1;
                mode_d   = ord_code[2];
                stk_d    = ord_stack(ord_code);
              end else begin
                st_d      = SQ_IDLE;
                bad_order = 1'b1;
              end
            end
          end
        end
        SQ_XFER: begin
          if (tmr_done) begin
            xfer_req = 1'b1;
            if (xfer_ack) begin
              tmr_load = 1'b1;
              if (xfer_zbc || xfer_last) begin
                st_d    = SQ_END;
                len_err = xfer_zbc ^ xfer_last;
              end
            end
          end
        end
        SQ_END: begin
          if (tmr_done) begin
            card_done = 1'b1;
            if (chain_in) begin
              st_d     = SQ_FETCH;
              tmr_load = 1'b1;
            end else begin
              st_d = SQ_IDLE;
            end
          end
        end
        default: st_d = SQ_IDLE;
      endcase
    end
    st_en = (st_d != st_q) || (mode_d != mode_q) || (stk_d != stk_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      mode_q <= 1'b0;
      stk_q  <= STK_NORM;
    end else if (st_en) begin
      st_q   <= st_d;
      mode_q <= mode_d;
      stk_q  <= stk_d;
    end
  end

  assign busy      = (st_q != SQ_IDLE);
  assign mode_auto = mode_q;
  assign stk_sel   = stk_q;
endmodule

// File: rtl/crd_deck_cnt.sv
module crd_deck_cnt
  import crd_pkg::*;
#(
  parameter int HOP_W = 12,
  parameter int STK_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [HOP_W-1:0] load_val,
  input  logic             card_done,
  input  logic [1:0]       sel,
  output logic [HOP_W-1:0] hopper,
  output logic             attached,
  output logic [NSTK*STK_W-1:0] stk_all
);
  localparam logic [HOP_W-1:0] HOP_ONE = HOP_W'(1);
  localparam logic [STK_W-1:0] STK_ONE = STK_W'(1);

  logic [HOP_W-1:0] hop_q, hop_d;
  logic             att_q, att_d;
  logic             hop_en;

  always_comb begin
    hop_d  = hop_q;
    att_d  = att_q;
    hop_en = 1'b0;
    if (load) begin
      hop_d  = load_val;
      att_d  = (load_val != '0);
      hop_en = 1'b1;
    end else if (card_done && (hop_q != '0)) begin
      hop_d  = hop_q - HOP_ONE;
      att_d  = (hop_q != HOP_ONE);
      hop_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hop_q <= '0;
      att_q <= 1'b0;
    end else if (hop_en) begin
      hop_q <= hop_d;
      att_q <= att_d;
    end
  end

  for (genvar g = 0; g < NSTK; g++) begin : g_stk
    logic [STK_W-1:0] q;
    logic             inc;
    assign inc = card_done && (sel == 2'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (inc) q <= q + STK_ONE;
    end
    assign stk_all[g*STK_W +: STK_W] = q;
  end

  assign hopper   = hop_q;
  assign attached = att_q;
endmodule

// File: rtl/crd_chan_ctl.sv
module crd_chan_ctl
  import crd_pkg::*;
#(
  parameter int CTL_DLY = 4,
  parameter int HOP_W   = 12,
  parameter int STK_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  output logic [7:0]       status_word,
  input  logic             hopper_load,
  input  logic [HOP_W-1:0] hopper_init,
  output logic             ord_req,
  input  logic             ord_valid,
  input  logic [7:0]       ord_code,
  output logic             xfer_req,
  input  logic             xfer_ack,
  input  logic             xfer_zbc,
  input  logic             xfer_last,
  input  logic             data_err_in,
  input  logic             chain_in,
  output logic             mode_auto,
  output logic [1:0]       stk_sel,
  output logic             chan_end,
  output logic             unusual_end,
  output logic             len_err,
  output logic             int_pend,
  output logic             attached,
  output logic [HOP_W-1:0] hopper_cnt,
  output logic [STK_W-1:0] stk_norm,
  output logic [STK_W-1:0] stk_alt1,
  output logic [STK_W-1:0] stk_alt2
);
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  host_op_e op;
  logic     seq_busy, start_go, halt_go, tmr_load, tmr_done;
  logic     card_done, bad_order;
  logic     is_halt, is_ack;
  logic [NSTK*STK_W-1:0] stk_all;

  assign op       = host_op_e'(cmd_op);
  assign is_halt  = cmd_valid && (op == HC_HALT);
  assign is_ack   = cmd_valid && (op == HC_ACK);
  assign start_go = cmd_valid && (op == HC_START) && attached && !seq_busy;
  assign halt_go  = is_halt && seq_busy;

  crd_dly_timer #(.CTL_DLY(CTL_DLY)) u_tmr (
    .clk(clk), .rst_n(rst_n_s), .load(tmr_load), .done(tmr_done)
  );

  crd_seq u_seq (
    .clk(clk), .rst_n(rst_n_s), .start_go(start_go), .halt_go(halt_go),
    .tmr_done(tmr_done), .ord_valid(ord_valid), .ord_code(ord_code),
    .xfer_ack(xfer_ack), .xfer_zbc(xfer_zbc), .xfer_last(xfer_last),
    .chain_in(chain_in), .tmr_load(tmr_load), .busy(seq_busy),
    .ord_req(ord_req), .xfer_req(xfer_req), .card_done(card_done),
    .bad_order(bad_order), .len_err(len_err), .mode_auto(mode_auto),
    .stk_sel(stk_sel)
  );

  crd_deck_cnt #(.HOP_W(HOP_W), .STK_W(STK_W)) u_deck (
    .clk(clk), .rst_n(rst_n_s), .load(hopper_load), .load_val(hopper_init),
    .card_done(card_done), .sel(stk_sel), .hopper(hopper_cnt),
    .attached(attached), .stk_all(stk_all)
  );

  assign stk_norm = stk_all[0*STK_W +: STK_W];
  assign stk_alt1 = stk_all[1*STK_W +: STK_W];
  assign stk_alt2 = stk_all[2*STK_W +: STK_W];

  assign chan_end    = card_done;
  assign unusual_end = bad_order || halt_go;

  // interrupt pending: raised by an ending, dropped by halt or acknowledge
  logic int_q, int_d, int_en;
  always_comb begin
    int_d  = int_q;
    if (is_halt || is_ack)         int_d = 1'b0;
    if (card_done || bad_order)    int_d = 1'b1;
    int_en = (int_d != int_q);
  end

  // unit status data-error flag
  logic derr_q, derr_d, derr_en;
  always_comb begin
    derr_d = derr_q;
    if (start_go)                     derr_d = 1'b0;
    else if (data_err_in && seq_busy) derr_d = 1'b1;
    derr_en = (derr_d != derr_q);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      int_q  <= 1'b0;
      derr_q <= 1'b0;
    end else begin
      if (int_en)  int_q  <= int_d;
      if (derr_en) derr_q <= derr_d;
    end
  end
  assign int_pend = int_q;

  logic [7:0] test_word, tdev_word;
  always_comb begin
    test_word = '0;
    test_word[ST_AUTO_B]  = attached;
    test_word[ST_CBUSY_B] = seq_busy;
    test_word[ST_DBUSY_B] = seq_busy;
    tdev_word = '0;
    if (attached && (hopper_cnt != '0)) tdev_word[UST_DERR_B] = derr_q;
    else                                tdev_word[ST_NRDY_B]  = 1'b1;
    status_word = '0;
    if (cmd_valid) begin
      case (op)
        HC_START, HC_TEST, HC_HALT: status_word = test_word;
        HC_TDEV:                    status_word = tdev_word;
        default:                    status_word = '0;
      endcase
    end
  end
endmodule

// File: rtl/crd_chan_ctl_chk.sv
module crd_chan_ctl_chk #(
  parameter int HOP_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [2:0]       cmd_op,
  input logic             seq_busy,
  input logic             attached,
  input logic             ord_req,
  input logic             ord_valid,
  input logic             xfer_req,
  input logic             xfer_ack,
  input logic             xfer_zbc,
  input logic             xfer_last,
  input logic             chan_end,
  input logic             chain_in,
  input logic             unusual_end,
  input logic             len_err,
  input logic             int_pend,
  input logic             hopper_load,
  input logic [HOP_W-1:0] hopper_cnt
);
  localparam logic [HOP_W-1:0] HOP_ONE = HOP_W'(1);

  AST_BAD_ORDER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ord_req && ord_valid && unusual_end |=> !seq_busy); // R1
  AST_NO_LAUNCH_DETACHED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 3'd0 && !attached && !seq_busy |=> !seq_busy); // R4
  AST_HALT_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 3'd3 && seq_busy |-> unusual_end); // R5
  AST_HALT_IDLE_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 3'd3 && seq_busy |=> !seq_busy); // R5
  AST_LEN_ON_FINAL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |-> xfer_ack && (xfer_zbc != xfer_last)); // R6
  AST_HOPPER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    chan_end && !hopper_load && hopper_cnt != '0 |=> hopper_cnt == $past(hopper_cnt) - HOP_ONE); // R7
  AST_END_NO_CHAIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    chan_end && !chain_in |=> !seq_busy && int_pend); // R8
  AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(chan_end && unusual_end)); // R8
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ord_req && xfer_req)); // R12
  AST_ACK_CLEARS_INT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 3'd4 && !chan_end && !unusual_end |=> !int_pend); // R13
endmodule

bind crd_chan_ctl crd_chan_ctl_chk #(.HOP_W(HOP_W)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .seq_busy(seq_busy), .attached(attached), .ord_req(ord_req),
  .ord_valid(ord_valid), .xfer_req(xfer_req), .xfer_ack(xfer_ack),
  .xfer_zbc(xfer_zbc), .xfer_last(xfer_last), .chan_end(chan_end),
  .chain_in(chain_in), .unusual_end(unusual_end), .len_err(len_err),
  .int_pend(int_pend), .hopper_load(hopper_load), .hopper_cnt(hopper_cnt)
);

// File: tb/crd_chan_ctl_bench.sv
module crd_chan_ctl_bench;
  localparam int D  = 2;
  localparam int HW = 6;
  localparam int SW = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid, hopper_load, ord_valid, xfer_ack, xfer_zbc, xfer_last;
  logic data_err_in, chain_in;
  logic [2:0] cmd_op;
  logic [7:0] status_word, ord_code;
  logic [HW-1:0] hopper_init, hopper_cnt;
  logic ord_req, xfer_req, mode_auto, chan_end, unusual_end, len_err, int_pend, attached;
  logic [1:0] stk_sel;
  logic [SW-1:0] stk_norm, stk_alt1, stk_alt2;

  always #10 clk = ~clk;

  crd_chan_ctl #(.CTL_DLY(D), .HOP_W(HW), .STK_W(SW)) u_crd_chan_ctl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .status_word(status_word), .hopper_load(hopper_load), .hopper_init(hopper_init),
    .ord_req(ord_req), .ord_valid(ord_valid), .ord_code(ord_code),
    .xfer_req(xfer_req), .xfer_ack(xfer_ack), .xfer_zbc(xfer_zbc),
    .xfer_last(xfer_last), .data_err_in(data_err_in), .chain_in(chain_in),
    .mode_auto(mode_auto), .stk_sel(stk_sel), .chan_end(chan_end),
    .unusual_end(unusual_end), .len_err(len_err), .int_pend(int_pend),
    .attached(attached), .hopper_cnt(hopper_cnt), .stk_norm(stk_norm),
    .stk_alt1(stk_alt1), .stk_alt2(stk_alt2)
  );

  int checks = 0;
  int fails  = 0;
  int est[3] = '{0, 0, 0};
  int ehop   = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  function automatic bit exp_ok(input int c);
    return (c <= 8'h3E) && ((c & 3) == 2) && !(c >= 8'h20 && c <= 8'h2F);
  endfunction

  function automatic int exp_stk(input int c);
    int f = (c >> 4) & 3;
    return (f == 1) ? 1 : (f == 3) ? 2 : 0;
  endfunction

  task automatic host(input int op, output int st, output int ue);
    cmd_valid = 1'b1;
    cmd_op = 3'(op);
    #1;
    st = int'(status_word);
    ue = int'(unusual_end);
    step();
    cmd_valid = 1'b0;
  endtask

  task automatic load_hopper(input int n);
    hopper_load = 1'b1;
    hopper_init = HW'(n);
    step();
    hopper_load = 1'b0;
    ehop = n;
  endtask

  task automatic fetch(input int code, output int ue, output int gap);
    gap = 0;
    while (!ord_req && gap < 40) begin step(); gap++; end
    ord_valid = 1'b1;
    ord_code = 8'(code);
    #1;
    ue = int'(unusual_end);
    step();
    ord_valid = 1'b0;
  endtask

  task automatic check_counts(input string req);
    chk(req, "stk_norm", int'(stk_norm), est[0]);
    chk(req, "stk_alt1", int'(stk_alt1), est[1]);
    chk(req, "stk_alt2", int'(stk_alt2), est[2]);
    chk("R7", "hopper_cnt", int'(hopper_cnt), ehop);
  endtask

  // transfer part of a card; zb < 0 means the byte count never runs out
  task automatic body(input int code, input int nb, input int zb, input bit chain,
                      input bit derr, input bit gapchk);
    int gap, le, ce;
    bit z, l;
    for (int i = 0; i < nb; i++) begin
      gap = 0;
      while (!xfer_req && gap < 40) begin step(); gap++; end
      if (gapchk || i > 0) chk("R12", "xfer gap", gap, D);
      z = (i == zb);
      l = (i == nb - 1);
      xfer_ack = 1'b1; xfer_zbc = z; xfer_last = l;
      data_err_in = derr && (i == 0);
      #1;
      le = int'(len_err);
      step();
      xfer_ack = 1'b0; xfer_zbc = 1'b0; xfer_last = 1'b0; data_err_in = 1'b0;
      if (z || l) begin
        chk("R6", "len_err", le, int'(z != l));
        break;
      end
      chk("R6", "len_err mid", le, 0);
    end
    gap = 0;
    while (!chan_end && gap < 40) begin step(); gap++; end
    chk("R12", "end gap", gap, D);
    chain_in = chain;
    #1;
    ce = int'(chan_end);
    step();
    chain_in = 1'b0;
    chk("R7", "chan_end", ce, 1);
    est[exp_stk(code)] = (est[exp_stk(code)] + 1) % (1 << SW);
    ehop = ehop - 1;
    check_counts("R3");
  endtask

  task automatic card(input int code, input int nb, input int zb, input bit chain, input bit derr);
    int ue, gap;
    fetch(code, ue, gap);
    chk("R4", "fetch gap", gap, D);
    chk("R1", "valid order uend", ue, 0);
    chk("R2", "mode_auto", int'(mode_auto), (code >> 2) & 1);
    chk("R3", "stk_sel", int'(stk_sel), exp_stk(code));
    body(code, nb, zb, chain, derr, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int st, ue, gap;
    rst_n = 1'b0;
    cmd_valid = 0; cmd_op = 0; hopper_load = 0; hopper_init = 0;
    ord_valid = 0; ord_code = 0; xfer_ack = 0; xfer_zbc = 0; xfer_last = 0;
    data_err_in = 0; chain_in = 0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();

    // reset state
    chk("R9", "reset ord_req", int'(ord_req), 0);
    chk("R9", "reset int_pend", int'(int_pend), 0);
    chk("R7", "reset attached", int'(attached), 0);
    check_counts("R11");
    host(1, st, ue); chk("R9", "test detached", st, 8'h00);
    host(2, st, ue); chk("R10", "tdev detached", st, 8'h04);

    // start on detached reader is ignored
    host(0, st, ue); chk("R4", "start detached status", st, 8'h00);
    repeat (D + 3) step();
    chk("R4", "no fetch when detached", int'(ord_req), 0);
    host(1, st, ue); chk("R4", "still idle", st, 8'h00);

    load_hopper(50);
    chk("R7", "attached after load", int'(attached), 1);
    host(2, st, ue); chk("R10", "tdev loaded", st, 8'h00);

    // sweep every order code
    for (int c = 0; c < 256; c++) begin
      host(0, st, ue); chk("R4", "start status", st, 8'h80);
      fetch(c, ue, gap);
      chk("R4", "fetch delay", gap, D);
      chk("R1", "order check", ue, int'(!exp_ok(c)));
      if (exp_ok(c)) begin
        chk("R2", "mode_auto", int'(mode_auto), (c >> 2) & 1);
        chk("R3", "stk_sel", int'(stk_sel), exp_stk(c));
        host(1, st, ue); chk("R9", "test busy", st, 8'hE0);
        host(3, st, ue); chk("R5", "halt busy uend", ue, 1);
        chk("R5", "halt busy status", st, 8'hE0);
        host(1, st, ue); chk("R5", "idle after halt", st, 8'h80);
      end else begin
        chk("R1", "int after bad order", int'(int_pend), 1);
        host(1, st, ue); chk("R1", "idle after bad order", st, 8'h80);
        if (c == 0) begin
          host(3, st, ue);
          chk("R5", "halt idle no uend", ue, 0);
          chk("R5", "halt clears int", int'(int_pend), 0);
        end else begin
          host(4, st, ue);
          chk("R13", "ack status", st, 0);
          chk("R13", "ack clears int", int'(int_pend), 0);
        end
      end
    end
    check_counts("R3");

    // length rules
    host(0, st, ue); card(8'h02, 4, 3, 0, 0);
    host(0, st, ue); card(8'h16, 4, 1, 0, 0);
    host(0, st, ue); card(8'h3E, 3, -1, 0, 0);
    chk("R8", "int after card", int'(int_pend), 1);
    host(1, st, ue); chk("R8", "idle after card", st, 8'h80);
    host(4, st, ue); chk("R13", "ack after card", int'(int_pend), 0);

    // command chaining
    host(0, st, ue); card(8'h32, 2, 1, 1, 0);
    host(1, st, ue); chk("R8", "busy after chain", st, 8'hE0);
    fetch(8'h06, ue, gap);
    chk("R8", "chained fetch delay", gap, D - 1);
    chk("R2", "chained mode", int'(mode_auto), 1);
    body(8'h06, 2, -1, 0, 0, 1'b1);
    host(4, st, ue);

    // start while busy has no effect
    host(0, st, ue);
    fetch(8'h12, ue, gap);
    host(0, st, ue); chk("R4", "start busy status", st, 8'hE0);
    chk("R4", "no refetch", int'(ord_req), 0);
    body(8'h12, 2, 1, 0, 0, 1'b0);
    host(4, st, ue);

    // data error lifecycle
    host(0, st, ue); card(8'h06, 2, 1, 0, 1);
    host(2, st, ue); chk("R10", "tdev data error", st, 8'h08);
    host(0, st, ue); card(8'h02, 1, 0, 0, 0);
    host(2, st, ue); chk("R10", "tdev cleared", st, 8'h00);
    host(4, st, ue);

    // stacker wrap
    for (int k = 0; k < 17; k++) begin
      host(0, st, ue); card(8'h12, 1, 0, 0, 0);
      chk("R11", "alt1 wrap", int'(stk_alt1), est[1]);
    end
    host(4, st, ue);

    // last card detaches
    load_hopper(1);
    host(0, st, ue); card(8'h02, 1, 0, 0, 0);
    chk("R7", "detached at zero", int'(attached), 0);
    host(1, st, ue); chk("R9", "test after empty", st, 8'h00);
    host(2, st, ue); chk("R10", "tdev after empty", st, 8'h04);
    host(0, st, ue);
    repeat (D + 3) step();
    chk("R4", "no fetch after empty", int'(ord_req), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule